// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable array device. It sits after the AND array. It takes the product terms meant for one device pin and ORs them into a single logic value. A polarity bit can invert that value. The cell then either drives the value straight to the pad or stores it in a D register first. It also chooses what enables the pad driver, and what signal returns to the AND array on the cell's feedback line.

Two mode bits are shared by every cell of the device, and one variant bit belongs to each cell. Together they select one of six legal variants, grouped into registered, simple and complex modes. A small control decoder turns the mode bits into a set of select strobes. A datapath holds the OR gate, the polarity XOR, the register, the output mux, the enable mux and the feedback mux. Inside the cell, product term 0 serves either as ordinary logic or as the per-cell pad enable. When it is the enable, it is removed from the OR gate.

Top module: `omc_cell`

## Requirements
- R1: While `rst_n` is low, and after it rises with no clock edge yet, the register holds 0. A cell in the registered variant (`cfgMode`=2'b10, `cellComb`=0, `polInv`=0) therefore shows `padOut`=0.
- R2: The cell value is the OR of all eight `terms` bits, XORed with `polInv`. Term 0 joins the OR only when it is not the enable source. In the combinational output variants, `padOut` equals this value in the same cycle.
- R3: In the registered variant, `padOut` shows the cell value captured at the last rising clock edge, and `fbOut` returns that same registered value.
- R4: In the registered variant, `padOe` equals the shared enable pin `oePin` (1 = drive).
- R5: In the registered-mode combinational variant (`cfgMode`=2'b10, `cellComb`=1), `padOe` equals `terms[0]`, term 0 is removed from the OR, and `fbOut` equals the cell's own pad `padIn`.
- R6: In the simple output variant (`cfgMode`=2'b01, `cellComb`=0), `padOe` is 1 whatever `oePin` is, term 0 joins the OR, and `fbOut` equals the neighbour's pad `nbrPadIn`.
- R7: In the simple input variant (`cfgMode`=2'b01, `cellComb`=1), `padOe` is 0 and `fbOut` equals `padIn`.
- R8: In the complex output variant (`cfgMode`=2'b11, `cellComb`=0), `padOe` equals `terms[0]`, term 0 is removed from the OR, and `fbOut` equals `padIn`.
- R9: In the complex input variant (`cfgMode`=2'b11, `cellComb`=1), `padOe` is 0 and `fbOut` equals `padIn`.
- R10: The illegal code `cfgMode`=2'b00 disables the driver (`padOe`=0) and makes `fbOut` equal `padIn`.
- R11: The register loads only at edges where `cfgMode`=2'b10. In every other mode it keeps its value, which shows on `padOut` as soon as the registered variant is selected again.
- R12: The polarity bit also applies before the register, so with `polInv`=1 the registered variant captures the inverted OR result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (the device's dedicated clock pin) |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| cfgMode | input | 2 | Device-wide mode: 10 registered, 01 simple, 11 complex, 00 illegal |
| cellComb | input | 1 | Per-cell variant bit within the selected mode |
| polInv | input | 1 | Per-cell polarity: 1 inverts the OR result |
| terms | input | NUM_TERMS | Product terms from the AND array; bit 0 may serve as the enable |
| padIn | input | 1 | Value sensed on this cell's pad |
| nbrPadIn | input | 1 | Value sensed on the neighbouring cell's pad |
| oePin | input | 1 | Shared output-enable pin, used in registered mode |
| padOut | output | 1 | Value presented to the pad driver |
| padOe | output | 1 | Pad driver enable |
| fbOut | output | 1 | Feedback line returned to the AND array |

## Verification
The hardest state to reach from the ports is a register that holds a value while the cell sits outside registered mode. This state only becomes visible after the mode changes back. The stimulus loads a 1 in registered mode and then moves to simple mode. It clears every term and lets several edges pass. It then selects the registered variant again between two edges, so `padOut` must show the held 1 before the next edge overwrites it. The bench uses a similar mid-cycle sampling to tell the registered path apart from the combinational one. Inputs change on the falling edge, and `padOut` must not follow them until the next rising edge.

// File: rtl/omc_pkg.sv
package omc_pkg;

  typedef enum logic [1:0] {
    MODE_ILLEGAL = 2'b00,
    MODE_SIMPLE  = 2'b01,
    MODE_REG     = 2'b10,
    MODE_COMPLEX = 2'b11
  } devMode_e;

  typedef enum logic [1:0] {
    EN_ALWAYS = 2'b00,
    EN_NEVER  = 2'b01,
    EN_PIN    = 2'b10,
    EN_TERM   = 2'b11
  } enSrc_e;

  typedef enum logic [1:0] {
    FB_REG   = 2'b00,
    FB_OWN   = 2'b01,
    FB_NEIGH = 2'b10
  } fbSrc_e;

  typedef struct packed {
    logic   outFromReg;
    logic   termZeroIsEn;
    logic   regLoad;
    enSrc_e enSel;
    fbSrc_e fbSel;
  } cellCtrl_t;

endpackage

// File: rtl/omc_ctrl.sv
module omc_ctrl
  import omc_pkg::*;
(
  input  logic [1:0] cfgMode,
  input  logic       cellComb,
  output cellCtrl_t  ctrl
);

  devMode_e modeDec;

  assign modeDec = devMode_e'(cfgMode);

  always_comb begin
    ctrl.outFromReg   = 1'b0;
    ctrl.termZeroIsEn = 1'b0;
    ctrl.regLoad      = 1'b0;
    ctrl.enSel        = EN_NEVER;
    ctrl.fbSel        = FB_OWN;
    unique case (modeDec)
      MODE_REG: begin
        ctrl.regLoad = 1'b1;
        if (cellComb) begin
          ctrl.termZeroIsEn = 1'b1;
          ctrl.enSel        = EN_TERM;
          ctrl.fbSel        = FB_OWN;
        end else begin
          ctrl.outFromReg = 1'b1;
          ctrl.enSel      = EN_PIN;
          ctrl.fbSel      = FB_REG;
        end
      end
      MODE_SIMPLE: begin
        if (cellComb) begin
          ctrl.enSel = EN_NEVER;
          ctrl.fbSel = FB_OWN;
        end else begin
          ctrl.enSel = EN_ALWAYS;
          ctrl.fbSel = FB_NEIGH;
        end
      end
      MODE_COMPLEX: begin
        if (cellComb) begin
          ctrl.enSel = EN_NEVER;
        end else begin
          ctrl.termZeroIsEn = 1'b1;
          ctrl.enSel        = EN_TERM;
        end
        ctrl.fbSel = FB_OWN;
      end
      default: begin
        ctrl.enSel = EN_NEVER;
        ctrl.fbSel = FB_OWN;
      end
    endcase
  end

endmodule

// File: rtl/omc_datapath.sv
module omc_datapath
  import omc_pkg::*;
#(
  parameter int   NUM_TERMS = 8,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TERMS-1:0] terms,
  input  logic                 polInv,
  input  logic                 padIn,
  input  logic                 nbrPadIn,
  input  logic                 oePin,
  input  cellCtrl_t            ctrl,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 fbOut,
  output logic                 regQ
);

  localparam int LAST_TERM = NUM_TERMS - 1;

  logic [LAST_TERM:0] gatedTerms;
  logic               sumOfTerms;
  logic               cellLogic;

  for (genvar gi = 0; gi < NUM_TERMS; gi++) begin : g_term
    if (gi == 0) begin : g_first
      assign gatedTerms[gi] = terms[gi] & ~ctrl.termZeroIsEn;
    end else begin : g_rest
      assign gatedTerms[gi] = terms[gi];
    end
  end

  assign sumOfTerms = |gatedTerms;
  assign cellLogic  = sumOfTerms ^ polInv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regQ <= RESET_VAL;
    end else if (ctrl.regLoad) begin
      regQ <= cellLogic;
    end
  end

  assign padOut = ctrl.outFromReg ? regQ : cellLogic;

  always_comb begin
    unique case (ctrl.enSel)
      EN_ALWAYS: padOe = 1'b1;
      EN_PIN:    padOe = oePin;
      EN_TERM:   padOe = terms[0];
      default:   padOe = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ctrl.fbSel)
      FB_REG:   fbOut = regQ;
      FB_NEIGH: fbOut = nbrPadIn;
      default:  fbOut = padIn;
    endcase
  end

endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfgMode,
  input  logic                 cellComb,
  input  logic                 polInv,
  input  logic [NUM_TERMS-1:0] terms,
  input  logic                 padIn,
  input  logic                 nbrPadIn,
  input  logic                 oePin,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 fbOut
);

  cellCtrl_t ctrl;
  logic      regQ;

  omc_ctrl u_ctrl (
    .cfgMode  (cfgMode),
    .cellComb (cellComb),
    .ctrl     (ctrl)
  );

  omc_datapath #(
    .NUM_TERMS (NUM_TERMS),
    .RESET_VAL (1'b0)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .terms    (terms),
    .polInv   (polInv),
    .padIn    (padIn),
    .nbrPadIn (nbrPadIn),
    .oePin    (oePin),
    .ctrl     (ctrl),
    .padOut   (padOut),
    .padOe    (padOe),
    .fbOut    (fbOut),
    .regQ     (regQ)
  );

endmodule

// File: rtl/omc_cell_chk.sv
module omc_cell_chk #(
  parameter int NUM_TERMS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cfgMode,
  input logic                 cellComb,
  input logic [NUM_TERMS-1:0] terms,
  input logic                 padIn,
  input logic                 nbrPadIn,
  input logic                 oePin,
  input logic                 padOe,
  input logic                 fbOut,
  input logic                 regQ
);

  a_r4_pin_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode == 2'b10 && !cellComb) |-> (padOe == oePin));

  a_r5_term_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode == 2'b10 && cellComb) |-> (padOe == terms[0] && fbOut == padIn));

  a_r6_simple_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode == 2'b01 && !cellComb) |-> (padOe && fbOut == nbrPadIn));

  a_r8_complex_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode == 2'b11 && !cellComb) |-> (padOe == terms[0] && fbOut == padIn));

  // R7 and R9: input variants never drive
  a_r7_input_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode != 2'b10 && cfgMode != 2'b00 && cellComb) |-> (!padOe && fbOut == padIn));

  a_r10_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode == 2'b00) |-> (!padOe && fbOut == padIn));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode != 2'b10) |=> $stable(regQ));

endmodule

bind omc_cell omc_cell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfgMode  (cfgMode),
  .cellComb (cellComb),
  .terms    (terms),
  .padIn    (padIn),
  .nbrPadIn (nbrPadIn),
  .oePin    (oePin),
  .padOe    (padOe),
  .fbOut    (fbOut),
  .regQ     (regQ)
);

// File: tb/tb_omc_cell.sv
module tb_omc_cell;

  localparam int NUM_TERMS = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           cfgMode = 2'b10;
  logic                 cellComb = 1'b0;
  logic                 polInv = 1'b0;
  logic [NUM_TERMS-1:0] terms = '0;
  logic                 padIn = 1'b0;
  logic                 nbrPadIn = 1'b0;
  logic                 oePin = 1'b0;
  logic                 padOut;
  logic                 padOe;
  logic                 fbOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  omc_cell #(.NUM_TERMS(NUM_TERMS)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgMode  (cfgMode),
    .cellComb (cellComb),
    .polInv   (polInv),
    .terms    (terms),
    .padIn    (padIn),
    .nbrPadIn (nbrPadIn),
    .oePin    (oePin),
    .padOut   (padOut),
    .padOe    (padOe),
    .fbOut    (fbOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic setUp(input logic [1:0] m, input logic cc, input logic pol,
                       input logic [NUM_TERMS-1:0] t);
    @(negedge clk);
    cfgMode  = m;
    cellComb = cc;
    polInv   = pol;
    terms    = t;
    #1;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 padOut in reset", padOut, 1'b0);
    rst_n = 1'b1;
    #1;
    chk("R1 padOut after release", padOut, 1'b0);
  endtask

  task automatic testRegistered();
    setUp(2'b10, 1'b0, 1'b0, 8'h04);
    chk("R3 no change before edge", padOut, 1'b0);
    @(posedge clk); #2;
    chk("R3 captured value", padOut, 1'b1);
    chk("R3 feedback from register", fbOut, 1'b1);
    setUp(2'b10, 1'b0, 1'b1, 8'h04);
    @(posedge clk); #2;
    chk("R12 inverted capture", padOut, 1'b0);
    oePin = 1'b0; #1;
    chk("R4 enable pin low", padOe, 1'b0);
    oePin = 1'b1; #1;
    chk("R4 enable pin high", padOe, 1'b1);
  endtask

  task automatic testRegComb();
    padIn = 1'b1;
    setUp(2'b10, 1'b1, 1'b0, 8'h01);
    chk("R5 enable from term0", padOe, 1'b1);
    chk("R5 term0 not in sum", padOut, 1'b0);
    chk("R5 feedback own pad", fbOut, 1'b1);
    setUp(2'b10, 1'b1, 1'b0, 8'h03);
    chk("R5 other term drives", padOut, 1'b1);
    setUp(2'b10, 1'b1, 1'b0, 8'h00);
    chk("R5 enable off", padOe, 1'b0);
    padIn = 1'b0;
  endtask

  task automatic testSimpleOut();
    oePin = 1'b0;
    setUp(2'b01, 1'b0, 1'b0, 8'h00);
    chk("R2 all terms low", padOut, 1'b0);
    chk("R6 enable ignores pin", padOe, 1'b1);
    setUp(2'b01, 1'b0, 1'b0, 8'h01);
    chk("R6 term0 joins sum", padOut, 1'b1);
    setUp(2'b01, 1'b0, 1'b0, 8'h80);
    chk("R2 top term", padOut, 1'b1);
    setUp(2'b01, 1'b0, 1'b1, 8'h00);
    chk("R2 polarity inverts", padOut, 1'b1);
    nbrPadIn = 1'b1; padIn = 1'b0; #1;
    chk("R6 feedback neighbour", fbOut, 1'b1);
    nbrPadIn = 1'b0; #1;
    chk("R6 feedback neighbour low", fbOut, 1'b0);
  endtask

  task automatic testInputsAndComplex();
    padIn = 1'b1;
    setUp(2'b01, 1'b1, 1'b0, 8'hFF);
    chk("R7 driver off", padOe, 1'b0);
    chk("R7 feedback own pad", fbOut, 1'b1);
    setUp(2'b11, 1'b0, 1'b0, 8'h01);
    chk("R8 enable from term0", padOe, 1'b1);
    chk("R8 term0 not in sum", padOut, 1'b0);
    chk("R8 feedback own pad", fbOut, 1'b1);
    setUp(2'b11, 1'b0, 1'b0, 8'h40);
    chk("R8 enable off", padOe, 1'b0);
    chk("R8 sum of other term", padOut, 1'b1);
    setUp(2'b11, 1'b1, 1'b0, 8'hFF);
    chk("R9 driver off", padOe, 1'b0);
    chk("R9 feedback own pad", fbOut, 1'b1);
    oePin = 1'b1;
    setUp(2'b00, 1'b0, 1'b0, 8'hFF);
    chk("R10 illegal driver off", padOe, 1'b0);
    chk("R10 illegal feedback", fbOut, 1'b1);
    padIn = 1'b0; #1;
    chk("R10 illegal feedback low", fbOut, 1'b0);
  endtask

  task automatic testHold();
    setUp(2'b10, 1'b0, 1'b0, 8'h02);
    @(posedge clk); #2;
    chk("R11 loaded one", padOut, 1'b1);
    setUp(2'b01, 1'b0, 1'b0, 8'h00);
    repeat (3) @(posedge clk);
    setUp(2'b11, 1'b0, 1'b0, 8'h00);
    @(posedge clk);
    setUp(2'b10, 1'b0, 1'b0, 8'h00);
    chk("R11 value held", padOut, 1'b1);
    @(posedge clk); #2;
    chk("R11 loads again", padOut, 1'b0);
  endtask

  initial begin
    testReset();
    testRegistered();
    testRegComb();
    testSimpleOut();
    testInputsAndComplex();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule